// File: doc/BRIEF.md
# Housekeeping Register Slave over SPI

This block lets an external host reach a small bank of 8-bit housekeeping registers over a four-wire SPI link. The host pulls the chip-select low and sends a command byte. It then sends a starting address byte, followed by any number of data bytes. With the read command, each data byte slot returns the register at the current pointer. With the write command, each data byte is stored at the pointer. The pointer steps up by one after every data byte, so a whole range of registers can move in one selection.

Most of the map is fixed identification values. A single writable location drives the chip's external reset line. The SPI pins are sampled by the block's own clock through a short synchronizer, and edges on SCK are detected in that clock domain. SCK must therefore run several times slower than `clk`. The chip reset is synchronous and active low.

Top module: `hk_spi_regs`

## Requirements
- R1: A transaction starts when `spi_csn` goes low; the first complete byte after that is the command. Raising `spi_csn` ends the transaction at once, and a byte with fewer than 8 clocked bits is discarded without effect.
- R2: Bytes on `spi_mosi` are shifted most-significant bit first, one bit per rising edge of `spi_sck`, which idles low.
- R3: During a read stream, the MSB of each returned byte is on `spi_miso` before the first rising SCK edge of that byte slot, and the remaining bits change only after falling SCK edges. `spi_miso` is 0 while `spi_csn` is high and during the command and address bytes.
- R4: Command 0x40 selects a streaming read and 0x80 a streaming write. Any other command makes the rest of the transaction ignored: no register changes, and `spi_miso` stays 0.
- R5: The byte after the command is the start address. Each data byte uses the next address, and the address wraps from 0xFF to 0x00.
- R6: Reads return 0x00, 0x14, 0x56, 0x05, 0x07, 0x01 at addresses 0 to 5, and 0x00 at addresses 6 and 8.
- R7: A write to address 7 stores bit 0 of the data. That bit drives `ext_reset_o` (1 = reset asserted), and address 7 reads back as `{7'b0, bit}`.
- R8: Writes to any address other than 7 have no effect, and addresses above 8 read as 0x00.
- R9: `rst_n` low at a rising `clk` edge clears the reset-control bit and returns the SPI framing to the command stage, even in the middle of a selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also samples the SPI pins |
| rst_n | input | 1 | Synchronous active-low chip reset |
| spi_sck | input | 1 | SPI serial clock from the host, idles low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| ext_reset_o | output | 1 | External reset control, 1 = asserted |

## Verification
The hardest conditions to reach are aborts in the middle of framing. These include a selection dropped after only a few bits of a write data byte, and a chip reset pulse while the chip-select is still low. In the second case, later bytes must be taken as a fresh command rather than as data. The stimulus builds both with a bit-count argument to the byte task and with a reset pulse between bytes inside one selection. It then checks that `ext_reset_o` and the read-back value did not change. Address wrap is reached by streaming a read from 0xFF, and a read stream over the whole map confirms that every value keeps its place.

// File: rtl/hk_pkg.sv
// Shared definitions for the housekeeping SPI register slave.
// Assumes 8-bit commands and addresses.
package hk_pkg;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DROP = 2'd3
    } phase_t;

    localparam logic [7:0] CMD_STREAM_RD = 8'h40;
    localparam logic [7:0] CMD_STREAM_WR = 8'h80;

    // Fixed identification contents of the read-only part of the map.
    function automatic logic [7:0] id_value(input logic [7:0] a);
        case (a)
            8'd1:    id_value = 8'h14;
            8'd2:    id_value = 8'h56;
            8'd3:    id_value = 8'h05;
            8'd4:    id_value = 8'h07;
            8'd5:    id_value = 8'h01;
            default: id_value = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/hk_spi_shifter.sv
// Bit-level SPI front end.
// - Synchronizes SCK, CSN and MOSI into clk.
// - Detects SCK edges and assembles received bytes MSB first.
// - Shifts the transmit byte out on falling edges.
// Assumes SCK is much slower than clk and that DW is a power of two.
module hk_spi_shifter #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          csn,
    input  logic          mosi,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          sel,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          miso
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic          sck_s, csn_s, mosi_s, sck_d;
    logic          rise, fall;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg, tx;

    generate
        if (SYNC_STAGES > 1) begin : g_sync
            logic [SYNC_STAGES-1:0] sck_p, csn_p, mosi_p;
            // Purpose: multi-stage synchronizer for the three SPI inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sck_p  <= '0;
                    csn_p  <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
                    csn_p  <= {csn_p[SYNC_STAGES-2:0], csn};
                    mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
                end
            end
            assign sck_s  = sck_p[SYNC_STAGES-1];
            assign csn_s  = csn_p[SYNC_STAGES-1];
            assign mosi_s = mosi_p[SYNC_STAGES-1];
        end else begin : g_single
            logic sck_r, csn_r, mosi_r;
            // Purpose: single-flop capture of the SPI inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sck_r  <= 1'b0;
                    csn_r  <= 1'b1;
                    mosi_r <= 1'b0;
                end else begin
                    sck_r  <= sck;
                    csn_r  <= csn;
                    mosi_r <= mosi;
                end
            end
            assign sck_s  = sck_r;
            assign csn_s  = csn_r;
            assign mosi_s = mosi_r;
        end
    endgenerate

    // Purpose: keep the previous SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;
    assign sel  = ~csn_s;

    // Purpose: receive shifter and bit counter, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                shreg   <= {shreg[DW-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
            end
        end
    end

    // Purpose: transmit register; load a new byte, shift after falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s)              tx <= '0;
        else if (load)                    tx <= load_data;
        else if (fall && bit_cnt != '0)   tx <= {tx[DW-2:0], 1'b0};
    end

    assign rx_byte = shreg;
    assign miso    = tx[DW-1];

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (tx == '0));                                   // R3
    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_s && !load && !fall) |=> $stable(tx));             // R3
    AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (bit_cnt == '0 && !byte_done));                // R1

endmodule

// File: rtl/hk_frame_ctl.sv
// Byte-level framing.
// - Decodes the command byte and captures the start address.
// - Steps the register pointer after each data byte.
// - Issues read loads and write strobes to the register bank.
// Assumes byte_done is a one-cycle pulse with rx_byte valid in that cycle.
module hk_frame_ctl
    import hk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_addr,
    output logic          load,
    output logic [DW-1:0] load_data,
    output logic          wr_en,
    output logic [DW-1:0] wr_addr,
    output logic          wr_bit
);
    phase_t        phase;
    logic          is_read;
    logic [DW-1:0] ptr;

    // Purpose: phase sequencing, command decode and pointer stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase   <= PH_CMD;
            is_read <= 1'b0;
            ptr     <= '0;
        end else if (byte_done) begin
            case (phase)
                PH_CMD: begin
                    if (rx_byte == CMD_STREAM_RD) begin
                        phase   <= PH_ADDR;
                        is_read <= 1'b1;
                    end else if (rx_byte == CMD_STREAM_WR) begin
                        phase   <= PH_ADDR;
                        is_read <= 1'b0;
                    end else begin
                        phase   <= PH_DROP;
                    end
                end
                PH_ADDR: begin
                    phase <= PH_DATA;
                    ptr   <= is_read ? rx_byte + 1'b1 : rx_byte;
                end
                PH_DATA: ptr <= ptr + 1'b1;
                default: phase <= PH_DROP;
            endcase
        end
    end

    // Purpose: read address select and strobes toward bank and shifter.
    always_comb begin
        rd_addr   = (phase == PH_ADDR) ? rx_byte : ptr;
        load      = byte_done && is_read && (phase == PH_ADDR || phase == PH_DATA);
        load_data = rd_data;
        wr_en     = byte_done && !is_read && (phase == PH_DATA);
        wr_addr   = ptr;
        wr_bit    = rx_byte[0];
    end

    AST_DROP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DROP) |=> (phase == PH_DROP || phase == PH_CMD)); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && byte_done && phase == PH_DATA) |=> (ptr == $past(ptr) + 1'b1)); // R5

endmodule

// File: rtl/hk_regbank.sv
// Register map: fixed identification values plus one writable
// external-reset control bit. Reads are combinational.
// Assumes DW >= 8.
module hk_regbank
    import hk_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NUM_REGS = 9,
    parameter int EXT_ADDR = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [DW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ext_reset
);
    localparam logic [DW-1:0] EXT_A  = DW'(EXT_ADDR);
    localparam logic [DW-1:0] LAST_A = DW'(NUM_REGS - 1);

    logic ext_bit;

    // Purpose: the only writable state, the external-reset control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ext_bit <= 1'b0;
        else if (wr_en && wr_addr == EXT_A)   ext_bit <= wr_bit;
    end

    // Purpose: read multiplexer over the map.
    always_comb begin
        if (rd_addr == EXT_A)        rd_data = {{(DW-1){1'b0}}, ext_bit};
        else if (rd_addr <= LAST_A)  rd_data = DW'(id_value(rd_addr[7:0]));
        else                         rd_data = '0;
    end

    assign ext_reset = ext_bit;

    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == EXT_A) |=> (ext_bit == $past(wr_bit)));  // R7
    AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == EXT_A) |=> $stable(ext_bit));           // R8
    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !ext_bit);                                         // R9

endmodule

// File: rtl/hk_spi_regs.sv
// Top level of the housekeeping SPI register slave.
// Wires the bit shifter, framing control and register bank together.
// Assumes spi_sck toggles at most once every four clk cycles.
module hk_spi_regs #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_REGS    = 9,
    parameter int EXT_ADDR    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic ext_reset_o
);
    logic          sel, byte_done, load, wr_en, wr_bit;
    logic [DW-1:0] rx_byte, load_data, rd_addr, rd_data, wr_addr;

    hk_spi_shifter #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
        .load(load), .load_data(load_data), .sel(sel), .byte_done(byte_done),
        .rx_byte(rx_byte), .miso(spi_miso)
    );

    hk_frame_ctl #(.DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done),
        .rx_byte(rx_byte), .rd_data(rd_data), .rd_addr(rd_addr), .load(load),
        .load_data(load_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit)
    );

    hk_regbank #(.DW(DW), .NUM_REGS(NUM_REGS), .EXT_ADDR(EXT_ADDR)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_reset(ext_reset_o)
    );

endmodule

// File: tb/tb_hk_spi_regs.sv
module tb_hk_spi_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, ext_rst;

    int tests = 0, fails = 0;
    bit idle = 1'b0;
    bit model_ext = 1'b0;

    always #10 clk = ~clk;

    hk_spi_regs dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn),
        .spi_mosi(mosi), .spi_miso(miso), .ext_reset_o(ext_rst)
    );

    // Behavioural map from the requirements.
    function automatic logic [7:0] ref_rd(input logic [7:0] a);
        case (a)
            8'd1: return 8'h14;
            8'd2: return 8'h56;
            8'd3: return 8'h05;
            8'd4: return 8'h07;
            8'd5: return 8'h01;
            8'd7: return {7'b0, model_ext};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Per-clock comparison while the link is idle.
    always @(negedge clk) begin
        if (idle && rst_n) begin
            chk("R3 idle miso", {7'b0, miso}, 8'h00);
            chk("R7 ext level", {7'b0, ext_rst}, {7'b0, model_ext});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        idle = 1'b0;
        @(negedge clk);
        csn = 1'b0;
        wait_clk(6);
    endtask

    task automatic cs_end();
        wait_clk(4);
        csn = 1'b1;
        wait_clk(6);
        idle = 1'b1;
    endtask

    // Clock out nbits of b (MSB first) and capture miso before each rise.
    task automatic spi_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            mosi = b[7-i];
            wait_clk(4);
            r[7-i] = miso;
            wait_clk(4);
            sck = 1'b1;
            wait_clk(8);
            sck = 1'b0;
        end
    endtask

    task automatic rd_stream(input logic [7:0] start, input int n, input string req);
        logic [7:0] r;
        cs_begin();
        spi_bits(8'h40, 8, r);
        chk({req, " miso in cmd"}, r, 8'h00);
        spi_bits(start, 8, r);
        chk({req, " miso in addr"}, r, 8'h00);
        for (int k = 0; k < n; k++) begin
            spi_bits(8'h00, 8, r);
            chk(req, r, ref_rd(start + 8'(k)));
        end
        cs_end();
    endtask

    task automatic wr_stream(input logic [7:0] start, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input int n);
        logic [7:0] r;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        cs_begin();
        spi_bits(8'h80, 8, r);
        spi_bits(start, 8, r);
        for (int k = 0; k < n; k++) begin
            spi_bits(d[k], 8, r);
            chk("R3 miso zero in write", r, 8'h00);
            if (start + 8'(k) == 8'd7) model_ext = d[k][0];
        end
        cs_end();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        wait_clk(5);
        chk("R9 reset ext", {7'b0, ext_rst}, 8'h00);
        chk("R9 reset miso", {7'b0, miso}, 8'h00);
        rst_n = 1'b1;
        wait_clk(4);
        idle = 1'b1;

        // R2 and R1: single read of the product ID.
        rd_stream(8'h03, 1, "R2 read addr 3");
        // R6 and R5: whole map in one stream.
        rd_stream(8'h00, 9, "R6 map stream");
        // R7: assert, read back, release.
        wr_stream(8'h07, 8'h01, 8'h00, 8'h00, 1);
        chk("R7 ext asserted", {7'b0, ext_rst}, 8'h01);
        rd_stream(8'h07, 1, "R7 readback 1");
        wr_stream(8'h07, 8'h00, 8'h00, 8'h00, 1);
        chk("R7 ext released", {7'b0, ext_rst}, 8'h00);
        wr_stream(8'h07, 8'hFF, 8'h00, 8'h00, 1);
        rd_stream(8'h07, 1, "R7 readback upper zero");
        wr_stream(8'h07, 8'h00, 8'h00, 8'h00, 1);
        // R8: writes to fixed and unmapped addresses.
        wr_stream(8'h03, 8'hAA, 8'h00, 8'h00, 1);
        wr_stream(8'h09, 8'hFF, 8'h00, 8'h00, 1);
        rd_stream(8'h03, 1, "R8 ro addr 3");
        rd_stream(8'h09, 1, "R8 unmapped 9");
        chk("R8 ext untouched", {7'b0, ext_rst}, 8'h00);
        // R5: write stream increments into address 7.
        wr_stream(8'h05, 8'h11, 8'h22, 8'h01, 3);
        chk("R5 stream write reached 7", {7'b0, ext_rst}, 8'h01);
        // R5: wrap from 0xFF.
        rd_stream(8'hFF, 3, "R5 wrap");
        // R4: unknown command, then bytes that would clear address 7.
        cs_begin();
        spi_bits(8'h55, 8, r);
        spi_bits(8'h07, 8, r);
        chk("R4 miso after bad cmd", r, 8'h00);
        spi_bits(8'h00, 8, r);
        chk("R4 miso after bad cmd", r, 8'h00);
        cs_end();
        chk("R4 ext unchanged", {7'b0, ext_rst}, 8'h01);
        // R1: partial data byte is discarded.
        cs_begin();
        spi_bits(8'h80, 8, r);
        spi_bits(8'h07, 8, r);
        spi_bits(8'h00, 5, r);
        cs_end();
        chk("R1 partial byte discarded", {7'b0, ext_rst}, 8'h01);
        // R1: partial command, then a clean read.
        cs_begin();
        spi_bits(8'h40, 4, r);
        cs_end();
        rd_stream(8'h02, 1, "R1 fresh frame after abort");
        // R9: reset inside a selection returns framing to the command stage.
        cs_begin();
        spi_bits(8'h80, 8, r);
        rst_n = 1'b0;
        wait_clk(3);
        model_ext = 1'b0;
        chk("R9 ext cleared by reset", {7'b0, ext_rst}, 8'h00);
        rst_n = 1'b1;
        wait_clk(4);
        spi_bits(8'h07, 8, r);
        spi_bits(8'h01, 8, r);
        chk("R9 miso zero after reset", r, 8'h00);
        cs_end();
        chk("R9 no write after mid-frame reset", {7'b0, ext_rst}, 8'h00);
        rd_stream(8'h04, 2, "R6 after reset");

        wait_clk(10);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule